// File: doc/BRIEF.md
# Microcoded Header Parsing Stage

One stage of a pipelined packet header parser. Each packet arrives as a wide vector of its leading header bits, along with metadata: the type of the header to be parsed here, the bit offset of that header, the key built by earlier stages, and an error flag with the index of the stage that raised it. The stage parses exactly one header. It reads a per-type microcode entry, picks fields at the header offset, works out the next header type and this header's size in bits, moves the offset forward, and shifts one field into the key. Consecutive stages, each with its own index, parse a packet's header stack in order.

All header-specific rules live in a microcode table indexed by header type. A write port can rewrite the table while traffic flows, so the stage logic is the same for every protocol. Packets that cannot be parsed are still passed on, marked with the index of this stage. Packets that already carry an error, or that carry the reserved "done" type, pass through unchanged.

Both packet interfaces use valid/ready. An item moves on a rising edge where valid and ready are both high. When `out_ready` is low, the output item and all its fields hold steady. Back-pressure reaches `in_ready` only when both internal registers are full. A packet needs two register stages from acceptance to output.

Top module: `hp_parse_stage`

## Requirements
- R1: A packet accepted at edge k appears on the output after edge k+1 if the output is not stalled. While `out_valid` is high and `out_ready` is low, every output holds. `in_ready` is high whenever `out_valid` is low.
- R2: The microcode entry used for a packet is the one that `in_type` selects in the table at the edge where the packet is accepted.
- R3: A field is read at absolute bit position `in_off + rel`, least significant bit first (`in_pkt[pos]` is field bit 0). It is masked to `wid` bits, with at most 16 bits. Bits beyond the 256-bit vector read as zero.
- R4: The next type is either the entry's constant or the low 4 bits of the next-type field, chosen by the entry's `nt_mode` bit (1 selects the field).
- R5: The size in bits is either `sz_const`, or `(length_field << sz_shift) + sz_const` when `sz_mode` is 1. `out_off = in_off + size`.
- R6: `out_key = (in_key << key_wid) | key_field`, truncated to 32 bits.
- R7: If `STAGE_IDX` is below the entry's `first` bound or above its `last` bound, the stage raises an error.
- R8: An entry with `vld` = 0, or an `in_off + size` greater than 256, raises an error. On any error, `out_err` = 1, `out_eloc` = `STAGE_IDX`, and type, offset, key and vector are unchanged.
- R9: A packet with `in_err` = 1 leaves with all fields unchanged.
- R10: A packet with `in_type` = 4'hF (done) leaves unchanged, with `out_err` = 0 unless it came in with an error.
- R11: A table write at an edge is seen by packets accepted at later edges. A packet accepted at the same edge as the write uses the old entry.
- R12: After reset, `out_valid` = 0 and every table entry is invalid, so any non-done, error-free packet comes out flagged with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Stage can accept an item |
| in_pkt | input | 256 | Leading packet bits |
| in_type | input | 4 | Header type to parse here |
| in_off | input | 9 | Bit offset of that header |
| in_key | input | 32 | Key so far |
| in_err | input | 1 | Packet already in error |
| in_eloc | input | 3 | Stage index of earlier error |
| out_valid | output | 1 | Output item valid |
| out_ready | input | 1 | Downstream accepts |
| out_pkt | output | 256 | Packet bits, unchanged |
| out_type | output | 4 | Next header type |
| out_off | output | 9 | Offset of next header |
| out_key | output | 32 | Updated key |
| out_err | output | 1 | Error flag |
| out_eloc | output | 3 | Stage index where error arose |
| wr_en | input | 1 | Microcode write strobe |
| wr_idx | input | 4 | Table entry to write |
| wr_data | input | 67 | Packed microcode entry |

## Verification
A microcode rewrite and a lookup of the same entry can land on the same clock edge. The bench provokes this by driving `wr_en` and a packet of the written type in the same cycle, with the pipeline empty and the output ready, so acceptance happens at that edge. The packet is judged against the old entry and the next packet of that type against the new one. Output stalls are also made to coincide with new arrivals, and a scoreboard checks that nothing is lost or altered.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int PKT_W  = 256;
  localparam int TYPE_W = 4;
  localparam int OFF_W  = 9;
  localparam int KEY_W  = 32;
  localparam int FLD_W  = 16;
  localparam int WID_W  = 5;
  localparam int SHF_W  = 3;
  localparam int STG_W  = 3;
  localparam int DEPTH  = 1 << TYPE_W;
  localparam logic [TYPE_W-1:0] DONE_TYPE = '1;

  typedef struct packed {
    logic              vld;
    logic              nt_mode;
    logic [TYPE_W-1:0] nt_const;
    logic [OFF_W-1:0]  nt_pos;
    logic [WID_W-1:0]  nt_wid;
    logic              sz_mode;
    logic [OFF_W-1:0]  sz_const;
    logic [OFF_W-1:0]  sz_pos;
    logic [WID_W-1:0]  sz_wid;
    logic [SHF_W-1:0]  sz_shift;
    logic [OFF_W-1:0]  key_pos;
    logic [WID_W-1:0]  key_wid;
    logic [STG_W-1:0]  first;
    logic [STG_W-1:0]  last;
  } uc_t;

  localparam int UC_W = $bits(uc_t);
endpackage

// File: rtl/hp_field_pick.sv
module hp_field_pick #(
  parameter int PKT_W = 256,
  parameter int OFF_W = 9,
  parameter int FLD_W = 16,
  parameter int WID_W = 5
) (
  input  logic [PKT_W-1:0] pkt,
  input  logic [OFF_W-1:0] base,
  input  logic [OFF_W-1:0] rel,
  input  logic [WID_W-1:0] wid,
  output logic [FLD_W-1:0] fld
);
  logic [OFF_W:0]     pos;
  logic [PKT_W-1:0]   shifted;
  logic [FLD_W-1:0]   mask;

  assign pos     = {1'b0, base} + {1'b0, rel};
  assign shifted = pkt >> pos;

  always_comb begin
    for (int i = 0; i < FLD_W; i++) mask[i] = (32'(wid) > i);
  end

  assign fld = shifted[FLD_W-1:0] & mask;
endmodule

// File: rtl/hp_ucode_table.sv
module hp_ucode_table #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int UC_W  = 67
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [UC_W-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [UC_W-1:0]  rd_data
);
  logic [UC_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) mem[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/hp_parse_stage.sv
module hp_parse_stage
  import hp_pkg::*;
#(
  parameter int STAGE_IDX = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PKT_W-1:0]  in_pkt,
  input  logic [TYPE_W-1:0] in_type,
  input  logic [OFF_W-1:0]  in_off,
  input  logic [KEY_W-1:0]  in_key,
  input  logic              in_err,
  input  logic [STG_W-1:0]  in_eloc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PKT_W-1:0]  out_pkt,
  output logic [TYPE_W-1:0] out_type,
  output logic [OFF_W-1:0]  out_off,
  output logic [KEY_W-1:0]  out_key,
  output logic              out_err,
  output logic [STG_W-1:0]  out_eloc,
  input  logic              wr_en,
  input  logic [TYPE_W-1:0] wr_idx,
  input  logic [UC_W-1:0]   wr_data
);
  localparam logic [STG_W-1:0] MY_IDX = STG_W'(STAGE_IDX);

  // table lookup
  logic [UC_W-1:0] tbl_rd;
  hp_ucode_table #(.DEPTH(DEPTH), .IDX_W(TYPE_W), .UC_W(UC_W)) i_tbl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(in_type), .rd_data(tbl_rd)
  );

  // first register: packet plus its microcode
  logic              s1_v;
  logic [PKT_W-1:0]  s1_pkt;
  logic [TYPE_W-1:0] s1_type;
  logic [OFF_W-1:0]  s1_off;
  logic [KEY_W-1:0]  s1_key;
  logic              s1_err;
  logic [STG_W-1:0]  s1_eloc;
  uc_t               s1_uc;

  logic s2_adv, s1_adv;
  assign s2_adv   = !out_valid || out_ready;
  assign s1_adv   = !s1_v || s2_adv;
  assign in_ready = s1_adv;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else if (s1_adv) s1_v <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_adv && in_valid) begin
      s1_pkt  <= in_pkt;
      s1_type <= in_type;
      s1_off  <= in_off;
      s1_key  <= in_key;
      s1_err  <= in_err;
      s1_eloc <= in_eloc;
      s1_uc   <= uc_t'(tbl_rd);
    end
  end

  // locate / extract
  logic [FLD_W-1:0] nt_fld, sz_fld, key_fld;
  hp_field_pick #(.PKT_W(PKT_W), .OFF_W(OFF_W), .FLD_W(FLD_W), .WID_W(WID_W)) i_pick_nt (
    .pkt(s1_pkt), .base(s1_off), .rel(s1_uc.nt_pos), .wid(s1_uc.nt_wid), .fld(nt_fld));
  hp_field_pick #(.PKT_W(PKT_W), .OFF_W(OFF_W), .FLD_W(FLD_W), .WID_W(WID_W)) i_pick_sz (
    .pkt(s1_pkt), .base(s1_off), .rel(s1_uc.sz_pos), .wid(s1_uc.sz_wid), .fld(sz_fld));
  hp_field_pick #(.PKT_W(PKT_W), .OFF_W(OFF_W), .FLD_W(FLD_W), .WID_W(WID_W)) i_pick_key (
    .pkt(s1_pkt), .base(s1_off), .rel(s1_uc.key_pos), .wid(s1_uc.key_wid), .fld(key_fld));

  // compute
  logic [31:0]       hdr_size, hdr_end;
  logic              bypass, out_of_range, overrun, fault;
  logic [TYPE_W-1:0] nt_val;
  logic [KEY_W-1:0]  key_val;

  always_comb begin
    hdr_size     = s1_uc.sz_mode ? ((32'(sz_fld) << s1_uc.sz_shift) + 32'(s1_uc.sz_const))
                                 : 32'(s1_uc.sz_const);
    hdr_end      = 32'(s1_off) + hdr_size;
    overrun      = hdr_end > 32'(PKT_W);
    out_of_range = (MY_IDX < s1_uc.first) || (MY_IDX > s1_uc.last);
    bypass       = s1_err || (s1_type == DONE_TYPE);
    fault        = !s1_uc.vld || out_of_range || overrun;
    nt_val       = s1_uc.nt_mode ? nt_fld[TYPE_W-1:0] : s1_uc.nt_const;
    key_val      = (s1_key << s1_uc.key_wid) | KEY_W'(key_fld);
  end

  // second register: results
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (s2_adv) out_valid <= s1_v;
  end

  always_ff @(posedge clk) begin
    if (s2_adv && s1_v) begin
      out_pkt <= s1_pkt;
      if (bypass) begin
        out_type <= s1_type;
        out_off  <= s1_off;
        out_key  <= s1_key;
        out_err  <= s1_err;
        out_eloc <= s1_eloc;
      end else if (fault) begin
        out_type <= s1_type;
        out_off  <= s1_off;
        out_key  <= s1_key;
        out_err  <= 1'b1;
        out_eloc <= MY_IDX;
      end else begin
        out_type <= nt_val;
        out_off  <= hdr_end[OFF_W-1:0];
        out_key  <= key_val;
        out_err  <= 1'b0;
        out_eloc <= s1_eloc;
      end
    end
  end
endmodule

// File: rtl/hp_stage_chk.sv
module hp_stage_chk
  import hp_pkg::*;
#(
  parameter int STAGE_IDX = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [TYPE_W-1:0] out_type,
  input logic [OFF_W-1:0]  out_off,
  input logic [KEY_W-1:0]  out_key,
  input logic              out_err,
  input logic [STG_W-1:0]  out_eloc
);
  assert_hold_on_stall_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_off)
      && $stable(out_key) && $stable(out_err) && $stable(out_eloc));

  assert_ready_when_empty_R1: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  assert_offset_in_vector_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_err |-> 32'(out_off) <= 32'(PKT_W));

  assert_eloc_not_later_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err |-> 32'(out_eloc) <= 32'(STAGE_IDX));
endmodule

bind hp_parse_stage hp_stage_chk #(.STAGE_IDX(STAGE_IDX)) i_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_type(out_type), .out_off(out_off),
  .out_key(out_key), .out_err(out_err), .out_eloc(out_eloc)
);

// File: tb/test_hp_parse_stage.sv
module test_hp_parse_stage;
  import hp_pkg::*;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [PKT_W-1:0] in_pkt = '0, out_pkt;
  logic [TYPE_W-1:0] in_type = '0, out_type;
  logic [OFF_W-1:0] in_off = '0, out_off;
  logic [KEY_W-1:0] in_key = '0, out_key;
  logic in_err = 0, out_err;
  logic [STG_W-1:0] in_eloc = '0, out_eloc;
  logic wr_en = 0;
  logic [TYPE_W-1:0] wr_idx = '0;
  logic [UC_W-1:0] wr_data = '0;

  always #5 clk = ~clk;

  hp_parse_stage #(.STAGE_IDX(2)) i_hp_parse_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pkt(in_pkt), .in_type(in_type), .in_off(in_off), .in_key(in_key),
    .in_err(in_err), .in_eloc(in_eloc), .out_valid(out_valid), .out_ready(out_ready),
    .out_pkt(out_pkt), .out_type(out_type), .out_off(out_off), .out_key(out_key),
    .out_err(out_err), .out_eloc(out_eloc), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  typedef struct {
    logic [PKT_W-1:0] pkt; logic [TYPE_W-1:0] typ; logic [OFF_W-1:0] off;
    logic [KEY_W-1:0] key; logic err; logic [STG_W-1:0] eloc; string tag;
  } item_t;

  item_t q[$];
  uc_t mirror [DEPTH];
  int errs = 0, checks = 0;
  bit bp_on = 0, done = 0;

  function automatic int pick(logic [PKT_W-1:0] p, int abs_pos, int w);
    logic [PKT_W-1:0] s;
    if (abs_pos >= PKT_W) return 0;
    s = p >> abs_pos;
    return int'(s[15:0]) & ((1 << w) - 1);
  endfunction

  function automatic item_t model(uc_t e, logic [PKT_W-1:0] p, logic [TYPE_W-1:0] t,
      logic [OFF_W-1:0] o, logic [KEY_W-1:0] k, logic er, logic [STG_W-1:0] el);
    item_t x; int sz, nf, lf, kf;
    x.pkt = p; x.typ = t; x.off = o; x.key = k; x.err = er; x.eloc = el;
    if (er || t == 4'hF) return x;
    lf = pick(p, int'(o) + int'(e.sz_pos), int'(e.sz_wid));
    sz = e.sz_mode ? (lf << e.sz_shift) + int'(e.sz_const) : int'(e.sz_const);
    if (!e.vld || 2 < int'(e.first) || 2 > int'(e.last) || int'(o) + sz > PKT_W) begin
      x.err = 1; x.eloc = 3'd2; return x;
    end
    nf = pick(p, int'(o) + int'(e.nt_pos), int'(e.nt_wid));
    kf = pick(p, int'(o) + int'(e.key_pos), int'(e.key_wid));
    x.typ = e.nt_mode ? 4'(nf) : e.nt_const;
    x.off = 9'(int'(o) + sz);
    x.key = (k << e.key_wid) | 32'(kf);
    return x;
  endfunction

  function automatic uc_t mk(bit v, bit ntm, int ntc, int ntp, int ntw, bit szm, int szc,
      int szp, int szw, int szs, int kp, int kw, int f, int l);
    uc_t e;
    e.vld = v; e.nt_mode = ntm; e.nt_const = 4'(ntc); e.nt_pos = 9'(ntp); e.nt_wid = 5'(ntw);
    e.sz_mode = szm; e.sz_const = 9'(szc); e.sz_pos = 9'(szp); e.sz_wid = 5'(szw);
    e.sz_shift = 3'(szs); e.key_pos = 9'(kp); e.key_wid = 5'(kw); e.first = 3'(f); e.last = 3'(l);
    return e;
  endfunction

  function automatic logic [PKT_W-1:0] rnd_pkt();
    logic [PKT_W-1:0] p;
    for (int i = 0; i < PKT_W / 32; i++) p[i*32 +: 32] = $urandom;
    return p;
  endfunction

  task automatic check(bit ok, string msg);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s", msg); end
  endtask

  task automatic write_uc(int idx, uc_t e);
    @(negedge clk); wr_en = 1; wr_idx = 4'(idx); wr_data = e;
    @(posedge clk); #1 wr_en = 0;
    mirror[idx] = e;
  endtask

  task automatic send(logic [PKT_W-1:0] p, int t, int o, logic [KEY_W-1:0] k,
      logic er, int el, string tag);
    item_t x;
    @(negedge clk);
    in_valid = 1; in_pkt = p; in_type = 4'(t); in_off = 9'(o); in_key = k;
    in_err = er; in_eloc = 3'(el);
    while (!in_ready) @(negedge clk);
    x = model(mirror[t], p, 4'(t), 9'(o), k, er, 3'(el)); x.tag = tag;
    q.push_back(x);
    @(posedge clk); #1 in_valid = 0;
  endtask

  // R11: write and lookup of the same entry at one edge
  task automatic collide(int t, uc_t e, logic [PKT_W-1:0] p, int o, string tag);
    item_t x;
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(t); wr_data = e;
    in_valid = 1; in_pkt = p; in_type = 4'(t); in_off = 9'(o); in_key = 32'h1;
    in_err = 0; in_eloc = 0;
    check(in_ready === 1'b1, $sformatf("R11 in_ready act=%b exp=1", in_ready));
    x = model(mirror[t], p, 4'(t), 9'(o), 32'h1, 0, 0); x.tag = tag;
    q.push_back(x);
    @(posedge clk); #1 in_valid = 0; wr_en = 0;
    mirror[t] = e;
  endtask

  // stall generator
  initial forever begin
    @(posedge clk); #1;
    out_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (!rst && out_valid && out_ready) begin
      if (q.size() == 0) check(0, "R1 unexpected output act=valid exp=none");
      else begin
        item_t x; x = q.pop_front();
        check(out_pkt === x.pkt && out_type === x.typ && out_off === x.off &&
              out_key === x.key && out_err === x.err && out_eloc === x.eloc,
          $sformatf("%s act type=%h off=%0d key=%h err=%b eloc=%0d exp type=%h off=%0d key=%h err=%b eloc=%0d pkt_ok=%b",
            x.tag, out_type, out_off, out_key, out_err, out_eloc,
            x.typ, x.off, x.key, x.err, x.eloc, out_pkt === x.pkt));
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [PKT_W-1:0] p;
    uc_t e1, e2, e3, e4, e5, e6;
    for (int i = 0; i < DEPTH; i++) mirror[i] = '0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(out_valid === 1'b0, $sformatf("R12 out_valid act=%b exp=0", out_valid));
    check(in_ready === 1'b1, $sformatf("R1 in_ready idle act=%b exp=1", in_ready));

    // R12: empty table flags error
    send(rnd_pkt(), 1, 0, 32'hAB, 0, 0, "R12 empty table");

    e1 = mk(1, 1, 0, 96, 16, 0, 112, 0, 0, 0, 96, 16, 0, 7);
    e2 = mk(1, 1, 0, 72, 8, 1, 0, 0, 4, 5, 96, 8, 1, 3);
    e3 = mk(1, 0, 5, 0, 0, 0, 40, 0, 0, 0, 0, 4, 4, 6);
    e4 = mk(1, 0, 1, 0, 0, 0, 300, 0, 0, 0, 0, 0, 0, 7);
    e5 = mk(0, 0, 1, 0, 0, 0, 8, 0, 0, 0, 0, 0, 0, 7);
    write_uc(1, e1); write_uc(2, e2); write_uc(3, e3); write_uc(4, e4); write_uc(5, e5);

    // R3 R4 R6: field next type and key merge
    p = rnd_pkt(); p[96 +: 16] = 16'h0802;
    send(p, 1, 0, 32'h0000_1234, 0, 0, "R3 R4 R6 field next type");
    // R5: length-scaled size
    p = rnd_pkt(); p[112 +: 4] = 4'h4; p[184 +: 8] = 8'h06;
    send(p, 2, 112, 32'hCAFE, 0, 0, "R5 scaled size");
    // R4: constant next type path (bounds fail though) and R7 bounds
    send(rnd_pkt(), 3, 8, 32'h5, 0, 0, "R7 stage out of bounds");
    // R8: overrun and invalid entry
    send(rnd_pkt(), 1, 150, 32'h7, 0, 0, "R8 overrun end");
    send(rnd_pkt(), 4, 0, 32'h7, 0, 0, "R8 overrun const");
    send(rnd_pkt(), 5, 0, 32'h7, 0, 0, "R8 invalid entry");
    // R5: exact fit at vector end
    send(rnd_pkt(), 1, 144, 32'h9, 0, 0, "R5 exact fit");
    // R9 / R10
    send(rnd_pkt(), 1, 0, 32'h11, 1, 1, "R9 errored pass");
    send(rnd_pkt(), 15, 33, 32'h22, 0, 0, "R10 done pass");
    send(rnd_pkt(), 15, 40, 32'h23, 1, 0, "R10 R9 done with error");

    // R11: collision then new entry visible
    repeat (4) @(negedge clk);
    e6 = mk(1, 0, 9, 0, 0, 0, 24, 0, 0, 0, 0, 8, 2, 2);
    collide(6, e6, rnd_pkt(), 16, "R11 same-edge old entry");
    send(rnd_pkt(), 6, 16, 32'h3, 0, 0, "R11 new entry visible");
    write_uc(6, mk(1, 0, 10, 0, 0, 0, 32, 0, 0, 0, 0, 0, 0, 7));
    send(rnd_pkt(), 6, 0, 32'h3, 0, 0, "R11 rewrite visible");

    // R1 R2: mixed traffic under back-pressure
    bp_on = 1;
    for (int n = 0; n < 80; n++) begin
      int ts[7] = '{1, 2, 3, 4, 5, 6, 15};
      send(rnd_pkt(), ts[$urandom % 7], $urandom % 256, $urandom,
           ($urandom % 5 == 0), $urandom % 2, "R1 R2 mixed traffic");
    end
    bp_on = 0;
    repeat (20) @(negedge clk);
    check(q.size() == 0, $sformatf("R1 pending act=%0d exp=0", q.size()));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule